// File: doc/BRIEF.md
# SDIO Card Interrupt and Read-Wait Monitor

This block sits beside an SD host's data path and looks after two side-band duties of an SDIO card. It watches the DAT1 line for the card's interrupt signal and raises a pending flag when the card pulls the line low inside a valid detection window. It also carries out the read-wait handshake: when software asks for a pause between read blocks, the block drives DAT2 low shortly after a block has ended and holds it there until the request is withdrawn.

The two event sources are the start of a read wait and a card interrupt. Each one has a pending bit and an enable bit. The enabled pending bits are merged into a single processor interrupt line, and software reads the pending bits to learn which event occurred. A small status word reports three things: the synchronized DAT1 level, whether the detection window is open and whether a read wait is in progress. The bus-mode input selects the detection window. In 1-bit mode the window is open whenever the card clock runs. In 4-bit mode it is open only during the gap between data blocks.

Top module: `sdio_irq_rw_mon`

## Requirements
- R1: During and right after a synchronous reset, both pending bits are 0, the interrupt output is 0, the DAT2 output enable is 0 and the DAT1 status level reads 1.
- R2: The DAT1 status level follows the DAT1 input through two flip-flops, so a change appears after the second rising clock edge.
- R3: In 1-bit mode (wide_bus_i = 0) with the card clock enabled, a synchronized DAT1 level of 0 sets pending bit 1 (card interrupt) at the next clock edge. This is the third edge after DAT1 falls.
- R4: In 1-bit mode with card_clk_en_i = 0, a low DAT1 never sets pending bit 1.
- R5: In 4-bit mode (wide_bus_i = 1), a low DAT1 sets pending bit 1 only in cycles where xfer_gap_i = 1, whatever the state of the card clock.
- R6: Suppose xfer_gap_i rises in a cycle where rw_en_i and rw_req_i are both 1, and both stay 1. Then dat2_oe_o goes to 1, with dat2_o = 0, after the second clock edge counted from that cycle. It stays at 1 while both inputs remain 1 and returns to 0 at the first edge where either one is 0.
- R7: A read wait does not start when rw_en_i or rw_req_i is 0 in the cycle where xfer_gap_i rises. It is also cancelled if either input drops before the drive begins.
- R8: The clock edge that starts driving DAT2 also sets pending bit 0 (read-wait start).
- R9: A 1 in bit i of irq_clr_i clears pending bit i at the next edge. If a new event for bit i is detected in that same cycle, the bit stays at 1.
- R10: irq_o is 1 exactly when some pending bit has its irq_en_i bit set. A pending bit whose enable is 0 does not raise irq_o.
- R11: stat_rw_o equals dat2_oe_o. stat_window_o is xfer_gap_i in 4-bit mode and card_clk_en_i in 1-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| dat1_i | input | 1 | DAT1 line level, asynchronous |
| wide_bus_i | input | 1 | 1 = 4-bit bus mode, 0 = 1-bit mode |
| card_clk_en_i | input | 1 | Card clock running |
| xfer_gap_i | input | 1 | High while the bus is between data blocks; its rising edge marks a block end |
| rw_en_i | input | 1 | Read-wait control enable |
| rw_req_i | input | 1 | Read-wait request |
| irq_en_i | input | 2 | Per-source enable (bit 0 read-wait start, bit 1 card interrupt) |
| irq_clr_i | input | 2 | Write-one-to-clear strobe for the pending bits |
| dat2_o | output | 1 | DAT2 drive value (0 while a read wait is active) |
| dat2_oe_o | output | 1 | DAT2 output enable |
| irq_o | output | 1 | Merged processor interrupt |
| pend_o | output | 2 | Pending bits |
| stat_dat1_o | output | 1 | Synchronized DAT1 level |
| stat_window_o | output | 1 | Interrupt detection window open |
| stat_rw_o | output | 1 | Read wait in progress |

## Verification
Directed sequences hold DAT1 low while the clock is gated in 1-bit mode and then ungate it. This separates a window that follows the clock from one that ignores it. DAT1 is also held low in 4-bit mode with the gap closed and then opened, which shows that the gap, and not the clock, controls detection there. The read-wait cases raise the gap with the enable cleared, with the request present, and with the request withdrawn. These confirm the two-edge start, the hold and the release, and a clear issued during a detection proves that a new event wins over the clear. Long random runs of mode, clock, gap, request, enable and clear traffic are compared against a cycle model in the bench, which exposes off-by-one latencies in the synchronizer and the read-wait counter.

// File: rtl/sdio_mon_pkg.sv
package sdio_mon_pkg;

    localparam int NSRC     = 2;
    localparam int SRC_RW   = 0;
    localparam int SRC_CARD = 1;

    typedef enum logic [1:0] {
        RW_IDLE = 2'd0,
        RW_WAIT = 2'd1,
        RW_HOLD = 2'd2
    } rw_state_e;

    // Window in which a low DAT1 counts as a card interrupt.
    function automatic logic det_window(logic wide, logic clk_on, logic gap);
        return wide ? gap : clk_on;
    endfunction

endpackage

// File: rtl/dat1_mon.sv
module dat1_mon
    import sdio_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dat1_in,
    input  logic wide_bus,
    input  logic card_clk_en,
    input  logic xfer_gap,
    output logic dat1_lvl,
    output logic window,
    output logic card_hit
);

    logic [SYNC_STAGES-1:0] sync_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= dat1_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], dat1_in};
            end
        end
    endgenerate

    assign dat1_lvl = sync_q[SYNC_STAGES-1];
    assign window   = det_window(wide_bus, card_clk_en, xfer_gap);
    assign card_hit = window && !dat1_lvl;

    // R2: the synchronized level only moves toward a value the input held earlier
    a_r2_sync_source: assert property (@(posedge clk) disable iff (rst)
        $fell(dat1_lvl) |-> $past(!sync_q[0]));

endmodule

// File: rtl/rw_ctrl.sv
module rw_ctrl
    import sdio_mon_pkg::*;
#(
    parameter int RW_DELAY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rw_en,
    input  logic rw_req,
    input  logic xfer_gap,
    output logic active,
    output logic start
);

    localparam int CNT_W = $clog2(RW_DELAY + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RW_DELAY - 1);

    rw_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic            gap_q;
    logic            go;
    logic            rise;

    assign go    = rw_en && rw_req;
    assign rise  = xfer_gap && !gap_q;
    assign start = (state_q == RW_WAIT) && go && (cnt_q == LAST);
    assign active = (state_q == RW_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RW_IDLE;
            cnt_q   <= '0;
            gap_q   <= 1'b0;
        end else begin
            gap_q <= xfer_gap;
            unique case (state_q)
                RW_IDLE: begin
                    if (rise && go) begin
                        state_q <= RW_WAIT;
                        cnt_q   <= CNT_W'(1);
                    end
                end
                RW_WAIT: begin
                    if (!go)             state_q <= RW_IDLE;
                    else if (cnt_q == LAST) state_q <= RW_HOLD;
                    else                 cnt_q   <= cnt_q + 1'b1;
                end
                RW_HOLD: begin
                    if (!go) state_q <= RW_IDLE;
                end
                default: state_q <= RW_IDLE;
            endcase
        end
    end

    // R6: hold ends on the first edge the request or enable is gone
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        (active && !go) |=> !active);

    // R7: drive only begins out of the waiting phase with the request present
    a_r7_from_wait: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(state_q == RW_WAIT && rw_req && rw_en));

endmodule

// File: rtl/irq_status.sv
module irq_status
    import sdio_mon_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set,
    input  logic [NSRC-1:0] clr,
    input  logic [NSRC-1:0] en,
    output logic [NSRC-1:0] pend,
    output logic            irq
);

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr) | set;
    end

    assign irq = |(pend & en);

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_chk
            // R9: a new event wins over a clear in the same cycle
            a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
                set[i] |=> pend[i]);
            // R9: clear without a new event empties the bit
            a_r9_clear: assert property (@(posedge clk) disable iff (rst)
                (clr[i] && !set[i]) |=> !pend[i]);
        end
    endgenerate

endmodule

// File: rtl/sdio_irq_rw_mon.sv
module sdio_irq_rw_mon
    import sdio_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RW_DELAY    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dat1_i,
    input  logic       wide_bus_i,
    input  logic       card_clk_en_i,
    input  logic       xfer_gap_i,
    input  logic       rw_en_i,
    input  logic       rw_req_i,
    input  logic [1:0] irq_en_i,
    input  logic [1:0] irq_clr_i,
    output logic       dat2_o,
    output logic       dat2_oe_o,
    output logic       irq_o,
    output logic [1:0] pend_o,
    output logic       stat_dat1_o,
    output logic       stat_window_o,
    output logic       stat_rw_o
);

    logic            card_hit;
    logic            rw_start;
    logic            rw_active;
    logic [NSRC-1:0] set_vec;

    dat1_mon #(.SYNC_STAGES(SYNC_STAGES)) u_dat1 (
        .clk         (clk),
        .rst         (rst),
        .dat1_in     (dat1_i),
        .wide_bus    (wide_bus_i),
        .card_clk_en (card_clk_en_i),
        .xfer_gap    (xfer_gap_i),
        .dat1_lvl    (stat_dat1_o),
        .window      (stat_window_o),
        .card_hit    (card_hit)
    );

    rw_ctrl #(.RW_DELAY(RW_DELAY)) u_rw (
        .clk      (clk),
        .rst      (rst),
        .rw_en    (rw_en_i),
        .rw_req   (rw_req_i),
        .xfer_gap (xfer_gap_i),
        .active   (rw_active),
        .start    (rw_start)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[SRC_RW]   = rw_start;
        set_vec[SRC_CARD] = card_hit;
    end

    irq_status u_irq (
        .clk  (clk),
        .rst  (rst),
        .set  (set_vec),
        .clr  (irq_clr_i),
        .en   (irq_en_i),
        .pend (pend_o),
        .irq  (irq_o)
    );

    assign dat2_oe_o = rw_active;
    assign dat2_o    = !rw_active;
    assign stat_rw_o = rw_active;

    // R4: gated clock in 1-bit mode cannot raise the card interrupt bit
    a_r4_clk_off: assert property (@(posedge clk) disable iff (rst)
        (!wide_bus_i && !card_clk_en_i && !pend_o[SRC_CARD]) |=> !pend_o[SRC_CARD]);

    // R5: closed gap in 4-bit mode cannot raise the card interrupt bit
    a_r5_gap_only: assert property (@(posedge clk) disable iff (rst)
        (wide_bus_i && !xfer_gap_i && !pend_o[SRC_CARD]) |=> !pend_o[SRC_CARD]);

    // R8: start of DAT2 drive coincides with the read-wait pending bit
    a_r8_rw_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(dat2_oe_o) |-> pend_o[SRC_RW]);

    // R10: with every enable clear the merged line stays quiet
    a_r10_masked: assert property (@(posedge clk) disable iff (rst)
        (irq_en_i == 2'b00) |-> !irq_o);

    // R10: merged line only fires with a pending source behind it
    a_r10_needs_pend: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pend_o != 2'b00));

endmodule

// File: tb/sdio_irq_rw_mon_tb.sv
`timescale 1ns/1ps
module sdio_irq_rw_mon_tb;

    logic       clk = 1'b0;
    logic       rst_v, dat1_v, wide_v, clken_v, gap_v, rwen_v, req_v;
    logic [1:0] en_v, clr_v;
    logic       dat2_o, dat2_oe_o, irq_o, stat_dat1_o, stat_window_o, stat_rw_o;
    logic [1:0] pend_o;

    int checks = 0;
    int errors = 0;

    // bench reference state
    logic       m_s1, m_s2, m_gapq;
    int         m_st, m_cnt;
    logic [1:0] m_pend;

    always #2.5 clk = ~clk;

    sdio_irq_rw_mon u_dut (
        .clk(clk), .rst(rst_v), .dat1_i(dat1_v), .wide_bus_i(wide_v),
        .card_clk_en_i(clken_v), .xfer_gap_i(gap_v), .rw_en_i(rwen_v),
        .rw_req_i(req_v), .irq_en_i(en_v), .irq_clr_i(clr_v),
        .dat2_o(dat2_o), .dat2_oe_o(dat2_oe_o), .irq_o(irq_o), .pend_o(pend_o),
        .stat_dat1_o(stat_dat1_o), .stat_window_o(stat_window_o), .stat_rw_o(stat_rw_o)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_window();
        return wide_v ? gap_v : clken_v;
    endfunction

    task automatic model_edge();
        logic det, rise, start, go;
        if (rst_v) begin
            m_s1 = 1'b1; m_s2 = 1'b1; m_gapq = 1'b0;
            m_st = 0; m_cnt = 0; m_pend = 2'b00;
        end else begin
            det   = !m_s2 && exp_window();
            rise  = gap_v && !m_gapq;
            go    = rwen_v && req_v;
            start = 1'b0;
            case (m_st)
                0: if (rise && go) begin m_st = 1; m_cnt = 1; end
                1: if (!go) m_st = 0;
                   else if (m_cnt == 1) begin m_st = 2; start = 1'b1; end
                   else m_cnt++;
                default: if (!go) m_st = 0;
            endcase
            m_pend = (m_pend & ~clr_v) | {det, start};
            m_s2 = m_s1; m_s1 = dat1_v; m_gapq = gap_v;
        end
    endtask

    task automatic compare_all();
        chk("R2 dat1 level", 8'(stat_dat1_o), 8'(m_s2));
        chk("R3 card pend", 8'(pend_o[1]), 8'(m_pend[1]));
        chk("R8 rw pend", 8'(pend_o[0]), 8'(m_pend[0]));
        chk("R6 dat2 oe", 8'(dat2_oe_o), 8'(m_st == 2));
        chk("R6 dat2 val", 8'(dat2_oe_o && dat2_o), 8'h0);
        chk("R10 irq", 8'(irq_o), 8'(|(m_pend & en_v)));
        chk("R11 rw flag", 8'(stat_rw_o), 8'(m_st == 2));
        chk("R11 window", 8'(stat_window_o), 8'(exp_window()));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (!rst_v) compare_all();
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5d10_c0de));
        rst_v = 1; dat1_v = 1; wide_v = 0; clken_v = 1; gap_v = 0;
        rwen_v = 0; req_v = 0; en_v = 2'b11; clr_v = 2'b00;
        steps(3);
        rst_v = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1 pend", 8'(pend_o), 8'h0);
        chk("R1 irq", 8'(irq_o), 8'h0);
        chk("R1 oe", 8'(dat2_oe_o), 8'h0);
        chk("R1 dat1", 8'(stat_dat1_o), 8'h1);

        // R4: clock gated in 1-bit mode, DAT1 low
        clken_v = 0; dat1_v = 0;
        steps(5);
        chk("R4 no detect clk off", 8'(pend_o[1]), 8'h0);
        chk("R2 level low", 8'(stat_dat1_o), 8'h0);
        // R3: clock back on, detected at next edge
        clken_v = 1;
        step();
        chk("R3 detect", 8'(pend_o[1]), 8'h1);
        chk("R10 irq on", 8'(irq_o), 8'h1);
        en_v = 2'b01;
        step();
        chk("R10 masked", 8'(irq_o), 8'h0);
        en_v = 2'b11;
        // R9: clear while event still present
        clr_v = 2'b10;
        step();
        chk("R9 set wins", 8'(pend_o[1]), 8'h1);
        clr_v = 2'b00; dat1_v = 1; clken_v = 0;
        steps(3);
        clr_v = 2'b10;
        step();
        chk("R9 cleared", 8'(pend_o[1]), 8'h0);
        clr_v = 2'b00;

        // R5: 4-bit mode, gap closed then open
        wide_v = 1; clken_v = 1; dat1_v = 0; gap_v = 0;
        steps(4);
        chk("R5 no detect gap closed", 8'(pend_o[1]), 8'h0);
        gap_v = 1;
        step();
        chk("R5 detect in gap", 8'(pend_o[1]), 8'h1);
        gap_v = 0; dat1_v = 1; wide_v = 0; clken_v = 0; clr_v = 2'b11;
        steps(3);
        clr_v = 2'b00;

        // R7: gap rises with control enable clear
        rwen_v = 0; req_v = 1; gap_v = 1;
        steps(4);
        chk("R7 no rw without enable", 8'(dat2_oe_o), 8'h0);
        chk("R7 no rw flag", 8'(pend_o[0]), 8'h0);
        gap_v = 0;
        step();
        // R7: cancelled during the delay
        rwen_v = 1; gap_v = 1;
        step();
        req_v = 0;
        steps(2);
        chk("R7 cancelled", 8'(dat2_oe_o), 8'h0);
        gap_v = 0;
        step();

        // R6 / R8: normal read wait
        req_v = 1; gap_v = 1;
        step();
        chk("R6 not yet", 8'(dat2_oe_o), 8'h0);
        step();
        chk("R6 drive on", 8'(dat2_oe_o), 8'h1);
        chk("R6 drive low", 8'(dat2_o), 8'h0);
        chk("R8 rw start flag", 8'(pend_o[0]), 8'h1);
        steps(3);
        chk("R6 held", 8'(dat2_oe_o), 8'h1);
        req_v = 0;
        step();
        chk("R6 released", 8'(dat2_oe_o), 8'h0);
        gap_v = 0; clr_v = 2'b11;
        step();
        clr_v = 2'b00;

        // random traffic against the reference
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 15) == 0) wide_v = ~wide_v;
            clken_v = ($urandom_range(0, 9) < 8);
            if ($urandom_range(0, 5) == 0) gap_v = ~gap_v;
            if ($urandom_range(0, 3) == 0) dat1_v = $urandom_range(0, 1);
            rwen_v = ($urandom_range(0, 9) < 8);
            if ($urandom_range(0, 7) == 0) req_v = ~req_v;
            en_v  = 2'($urandom_range(0, 3));
            clr_v = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule